// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This block gives a processor three byte-wide general-purpose ports, called A, B and C, plus a configuration register. All four sit behind one small register interface: an 8-bit write bus, an 8-bit read bus, a block select, separate read and write strobes and a 2-bit register index. Software writes a configuration word to choose the direction of Port A, Port B, the upper half of Port C and the lower half of Port C. It then writes bytes to the output ports and reads the input ports.

Port C can also be changed one bit at a time. A write to the configuration address with bit 7 clear does not reconfigure anything. It forces one chosen Port C bit to a given value. Pads are not modelled. Each port has a separate pin-input vector, a latched output vector and a per-bit output-enable vector. Only simple (mode 0) operation is implemented. Handshake mode fields are stored and read back, but they drive no logic.

Top module: `par_port_ctrl`

## Requirements
- R1: After reset the configuration register reads 0x9B. Every output-enable is 0 and every output latch is 0.
- R2: The register index selects the target: 0 is Port A, 1 is Port B, 2 is Port C and 3 is configuration. A write to a port index loads that port's output latch on the clock edge where `sel` and `wr_en` are both high.
- R3: A configuration write with bit 7 = 1 sets the port directions. Bit 4 controls Port A, bit 1 Port B, bit 3 Port C bits 7..4 and bit 0 Port C bits 3..0. In each of these bits 1 means input and 0 means output. Each output-enable bit equals the inverse of its direction bit.
- R4: A configuration write with bit 7 = 1 clears all three output latches to 0.
- R5: A configuration write with bit 7 = 0 sets Port C bit number wdata[3:1] to wdata[0]. The other Port C latch bits and the configuration register are unchanged. For example, 0x0F sets bit 7.
- R6: Reading a port, or a Port C nibble, that is configured as input returns the live pin values of that same cycle, with no latching.
- R7: Reading a port configured as output returns its output latch.
- R8: The two Port C nibbles follow their own direction bits on read and on output-enable.
- R9: No register changes on a clock edge unless `sel` and `wr_en` are both high.
- R10: Bits 6..5 and bit 2 of a mode-set word are stored and read back from index 3. They have no effect beyond what the direction bits give.
- R11: `rdata` is 0 whenever `sel` and `rd_en` are not both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Block select, active high |
| rd_en | input | 1 | Read strobe, active high |
| wr_en | input | 1 | Write strobe, active high |
| addr | input | 2 | Register index |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin inputs |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enables |

## Verification
A wrong stored direction shows at the output-enable pins on the edge after the configuration write. It also shows at the next read, because that read returns a latch instead of the pins, or the pins instead of the latch. A corrupted output latch appears on the output vector at once and on a readback of that output port. The bench therefore checks the enables and outputs right after each write, and reads back both latched and live values. The bit set/reset path is checked on the edge that follows each command, for both the bit it targets and the bits it must leave alone.

// File: rtl/ppc_pkg.sv
// Shared constants for the parallel port controller.
// Assumes an 8-bit data path; the field positions are part of the software contract.
package ppc_pkg;
    localparam int DW = 8;
    localparam logic [DW-1:0] CFG_RESET = 8'h9B;
    // configuration word bit positions
    localparam int CFG_CLO  = 0;
    localparam int CFG_B    = 1;
    localparam int CFG_CHI  = 3;
    localparam int CFG_A    = 4;
    localparam int CFG_KIND = 7;
    typedef enum logic [1:0] {
        IDX_A    = 2'd0,
        IDX_B    = 2'd1,
        IDX_C    = 2'd2,
        IDX_CTRL = 2'd3
    } reg_idx_e;
endpackage

// File: rtl/ppc_ctrl_reg.sv
// Configuration register and command decode.
// Assumes wr_ctrl is a one-cycle qualified write to the control index.
// Bit 7 of the data picks a mode-set word or a Port C bit command.
module ppc_ctrl_reg
    import ppc_pkg::*;
#(
    parameter int W = DW,
    localparam int IW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ctrl,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  cfg,
    output logic          mode_wr,
    output logic          bit_wr,
    output logic [IW-1:0] bit_idx,
    output logic          bit_val
);
    // split a control write into its two command kinds
    always_comb begin
        mode_wr = wr_ctrl &&  wdata[CFG_KIND];
        bit_wr  = wr_ctrl && !wdata[CFG_KIND];
        bit_idx = wdata[IW:1];
        bit_val = wdata[0];
    end

    // hold the last mode-set word
    always_ff @(posedge clk) begin
        if (!rst_n)       cfg <= CFG_RESET;
        else if (mode_wr) cfg <= wdata;
    end
endmodule

// File: rtl/ppc_out_latch.sv
// One output latch with whole-byte load, single-bit update and clear.
// Assumes clear has priority over a byte load, and a byte load over a bit update.
module ppc_out_latch #(
    parameter int W = 8,
    localparam int IW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr,
    input  logic [W-1:0]  wdata,
    input  logic          bit_wr,
    input  logic [IW-1:0] bit_idx,
    input  logic          bit_val,
    output logic [W-1:0]  q
);
    // update the latched output byte
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (clr)    q <= '0;
        else if (wr)     q <= wdata;
        else if (bit_wr) q[bit_idx] <= bit_val;
    end
endmodule

// File: rtl/ppc_read_mux.sv
// Read-back selection: live pins for input ports, the latch for output ports.
// Port C is resolved per nibble. The output is zero when no read is active.
module ppc_read_mux
    import ppc_pkg::*;
#(
    parameter int W = DW,
    localparam int H = W / 2
) (
    input  logic         rd_act,
    input  logic [1:0]   addr,
    input  logic [W-1:0] cfg,
    input  logic [W-1:0] a_q,
    input  logic [W-1:0] b_q,
    input  logic [W-1:0] c_q,
    input  logic [W-1:0] a_pin,
    input  logic [W-1:0] b_pin,
    input  logic [W-1:0] c_pin,
    output logic [W-1:0] rdata
);
    logic [W-1:0] c_view;
    logic [1:0]   c_dir;
    assign c_dir = {cfg[CFG_CHI], cfg[CFG_CLO]};

    for (genvar n = 0; n < 2; n++) begin : g_nib
        // each nibble picks its own source
        assign c_view[n*H +: H] = c_dir[n] ? c_pin[n*H +: H] : c_q[n*H +: H];
    end

    // steer the addressed register onto the read bus
    always_comb begin
        rdata = '0;
        if (rd_act) begin
            unique case (reg_idx_e'(addr))
                IDX_A:    rdata = cfg[CFG_A] ? a_pin : a_q;
                IDX_B:    rdata = cfg[CFG_B] ? b_pin : b_q;
                IDX_C:    rdata = c_view;
                IDX_CTRL: rdata = cfg;
            endcase
        end
    end
endmodule

// File: rtl/par_port_ctrl.sv
// Top level: three byte ports and a control register behind a strobed register bus.
// Assumes a synchronous bus and single-cycle write strobes. Only simple I/O mode exists.
module par_port_ctrl
    import ppc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel,
    input  logic       rd_en,
    input  logic       wr_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic [7:0] pa_in,
    output logic [7:0] pa_out,
    output logic [7:0] pa_oe,
    input  logic [7:0] pb_in,
    output logic [7:0] pb_out,
    output logic [7:0] pb_oe,
    input  logic [7:0] pc_in,
    output logic [7:0] pc_out,
    output logic [7:0] pc_oe
);
    localparam int IW = $clog2(DW);
    localparam int H  = DW / 2;

    logic          wr_act, rd_act;
    logic [DW-1:0] cfg;
    logic          mode_wr, bit_wr, bit_val;
    logic [IW-1:0] bit_idx;

    // qualify the bus strobes with the select
    assign wr_act = sel && wr_en;
    assign rd_act = sel && rd_en;

    ppc_ctrl_reg #(.W(DW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_ctrl(wr_act && reg_idx_e'(addr) == IDX_CTRL),
        .wdata(wdata), .cfg(cfg), .mode_wr(mode_wr),
        .bit_wr(bit_wr), .bit_idx(bit_idx), .bit_val(bit_val)
    );

    ppc_out_latch #(.W(DW)) u_a (
        .clk(clk), .rst_n(rst_n), .clr(mode_wr),
        .wr(wr_act && reg_idx_e'(addr) == IDX_A), .wdata(wdata),
        .bit_wr(1'b0), .bit_idx('0), .bit_val(1'b0), .q(pa_out)
    );

    ppc_out_latch #(.W(DW)) u_b (
        .clk(clk), .rst_n(rst_n), .clr(mode_wr),
        .wr(wr_act && reg_idx_e'(addr) == IDX_B), .wdata(wdata),
        .bit_wr(1'b0), .bit_idx('0), .bit_val(1'b0), .q(pb_out)
    );

    ppc_out_latch #(.W(DW)) u_c (
        .clk(clk), .rst_n(rst_n), .clr(mode_wr),
        .wr(wr_act && reg_idx_e'(addr) == IDX_C), .wdata(wdata),
        .bit_wr(bit_wr), .bit_idx(bit_idx), .bit_val(bit_val), .q(pc_out)
    );

    // drive enables from the inverted direction bits
    always_comb begin
        pa_oe = {DW{~cfg[CFG_A]}};
        pb_oe = {DW{~cfg[CFG_B]}};
        pc_oe = {{H{~cfg[CFG_CHI]}}, {H{~cfg[CFG_CLO]}}};
    end

    ppc_read_mux #(.W(DW)) u_rd (
        .rd_act(rd_act), .addr(addr), .cfg(cfg),
        .a_q(pa_out), .b_q(pb_out), .c_q(pc_out),
        .a_pin(pa_in), .b_pin(pb_in), .c_pin(pc_in),
        .rdata(rdata)
    );
endmodule

// File: rtl/par_port_ctrl_sva.sv
// Port-level properties for par_port_ctrl, attached with bind.
module par_port_ctrl_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       sel,
    input logic       rd_en,
    input logic       wr_en,
    input logic [1:0] addr,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic [7:0] pa_in,
    input logic [7:0] pa_out,
    input logic [7:0] pa_oe,
    input logic [7:0] pb_out,
    input logic [7:0] pc_out,
    input logic [7:0] pc_oe
);
    a_r2_port_a_load: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr_en && addr == 2'd0) |=> pa_out == $past(wdata));

    a_r3_enable_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr_en && addr == 2'd3 && wdata[7]) |=>
        (pa_oe == {8{~$past(wdata[4])}}) &&
        (pc_oe == {{4{~$past(wdata[3])}}, {4{~$past(wdata[0])}}}));

    a_r4_latch_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr_en && addr == 2'd3 && wdata[7]) |=>
        (pa_out == 8'h00) && (pb_out == 8'h00) && (pc_out == 8'h00));

    a_r5_bit_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr_en && addr == 2'd3 && !wdata[7]) |=>
        (pc_out[$past(wdata[3:1])] == $past(wdata[0])) &&
        $stable(pa_oe) && $stable(pc_oe) && $stable(pa_out));

    a_r6_live_pins: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && rd_en && addr == 2'd0 && pa_oe == 8'h00) |-> rdata == pa_in);

    a_r9_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && wr_en) |=>
        $stable(pa_out) && $stable(pb_out) && $stable(pc_out) && $stable(pc_oe));

    a_r11_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && rd_en) |-> rdata == 8'h00);
endmodule

bind par_port_ctrl par_port_ctrl_sva u_sva (
    .clk(clk), .rst_n(rst_n), .sel(sel), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .pa_in(pa_in),
    .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out), .pc_out(pc_out),
    .pc_oe(pc_oe)
);

// File: tb/par_port_ctrl_test.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module par_port_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
    int n_run = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    par_port_ctrl uut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; rd_en = 1'b1; addr = a;
        #1 d = rdata;
        sel = 1'b0; rd_en = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        bus_rd(2'd3, d);
        chk("R1 cfg", d, 8'h9B);
        chk("R1 pa_oe", pa_oe, 8'h00);
        chk("R1 pc_oe", pc_oe, 8'h00);
        chk("R1 pc_out", pc_out, 8'h00);
    endtask

    task automatic t_mode_82;
        logic [7:0] d;
        bus_wr(2'd3, 8'h82);
        chk("R3 pa_oe", pa_oe, 8'hFF);
        chk("R3 pb_oe", pb_oe, 8'h00);
        chk("R3 pc_oe", pc_oe, 8'hFF);
        bus_wr(2'd0, 8'h5A);
        chk("R2 pa_out", pa_out, 8'h5A);
        pa_in = 8'h13;
        bus_rd(2'd0, d);
        chk("R7 read A latch", d, 8'h5A);
        bus_wr(2'd1, 8'h33);
        pb_in = 8'hC4;
        bus_rd(2'd1, d);
        chk("R6 read B pins", d, 8'hC4);
        pb_in = 8'h19;
        bus_rd(2'd1, d);
        chk("R6 read B live", d, 8'h19);
    endtask

    task automatic t_clear;
        bus_wr(2'd2, 8'hF0);
        chk("R2 pc_out", pc_out, 8'hF0);
        bus_wr(2'd3, 8'h82);
        chk("R4 clear A", pa_out, 8'h00);
        chk("R4 clear C", pc_out, 8'h00);
        chk("R4 clear B", pb_out, 8'h00);
    endtask

    task automatic t_bits;
        logic [7:0] d;
        bus_wr(2'd3, 8'h80);
        bus_wr(2'd0, 8'h11);
        bus_wr(2'd3, 8'h0F);
        chk("R5 set bit7", pc_out, 8'h80);
        bus_wr(2'd3, 8'h03);
        chk("R5 set bit1", pc_out, 8'h82);
        bus_wr(2'd3, 8'h0E);
        chk("R5 clear bit7", pc_out, 8'h02);
        bus_rd(2'd3, d);
        chk("R5 cfg kept", d, 8'h80);
        chk("R5 A kept", pa_out, 8'h11);
    endtask

    task automatic t_nibbles;
        logic [7:0] d;
        bus_wr(2'd3, 8'h88);
        chk("R8 pc_oe", pc_oe, 8'h0F);
        pc_in = 8'hAB;
        bus_wr(2'd2, 8'h5C);
        bus_rd(2'd2, d);
        chk("R8 split read", d, 8'hAC);
    endtask

    task automatic t_strobes;
        @(negedge clk);
        bus_wr(2'd3, 8'h80);
        bus_wr(2'd0, 8'h77);
        @(negedge clk);
        sel = 1'b0; wr_en = 1'b1; addr = 2'd0; wdata = 8'h12;
        @(negedge clk);
        sel = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
        #1 chk("R11 no read strobe", rdata, 8'h00);
        @(negedge clk);
        sel = 1'b0; wr_en = 1'b0;
        chk("R9 A held", pa_out, 8'h77);
        @(negedge clk);
        sel = 1'b0; wr_en = 1'b1; addr = 2'd3; wdata = 8'h9B;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R9 enables held", pa_oe, 8'hFF);
    endtask

    task automatic t_modes;
        logic [7:0] d;
        bus_wr(2'd3, 8'hE5);
        bus_rd(2'd3, d);
        chk("R10 stored", d, 8'hE5);
        chk("R10 pa_oe", pa_oe, 8'hFF);
        chk("R10 pb_oe", pb_oe, 8'hFF);
        chk("R10 pc_oe", pc_oe, 8'hF0);
        bus_wr(2'd3, 8'h90);
        chk("R3 90 pa_oe", pa_oe, 8'h00);
        chk("R3 90 pb_oe", pb_oe, 8'hFF);
        chk("R3 90 pc_oe", pc_oe, 8'hFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mode_82();
        t_clear();
        t_bits();
        t_nibbles();
        t_strobes();
        t_modes();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #100000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule